// File: doc/BRIEF.md
# Dual-Style Host Bus Front End

This block is the register-access front end between an 8-bit host processor and a set of internal registers and memories. The host bus has a 9-bit address, an 8-bit data bus and a chip select. A static style input chooses how the two remaining control pins are used. With style low they are separate active-low read and write strobes. With style high the first pin is a single active-low data strobe and the second is a direction line: high means read, low means write.

All host controls are brought into the system clock through two-flop synchronisers. Address and data go through a matching two-stage sample pipeline. A write produces a single-cycle internal write pulse after the trailing edge of the access, carrying the address and data that were on the bus while the strobe was held. A read produces a single-cycle internal read pulse at the leading edge. The returned value is captured the next cycle and driven onto the data bus through a separate output enable. The pad cell does the tri-stating.

An optional multiplexed-address mode takes the address from the bus on the falling edge of an address-latch strobe. A configurable address window is reserved. Writes there are swallowed and reads there return zero, with no internal pulse in either case.

Top module: `hb_host_if`

## Requirements
- R1: With style_i = 0, an access needs cs_ni low. rd_ni low is a read and wr_ni low is a write. The write data is the bus value present while wr_ni is low, before it rises.
- R2: With style_i = 1, an access needs cs_ni low and rd_ni (data strobe) low. wr_ni is the direction: 1 = read, 0 = write.
- R3: data_oe_o is high only during a read access, once the read data has been loaded. While it is high, data_o carries the loaded read data. It is never high during a write access.
- R4: data_oe_o falls no later than one clock after cs_ni rises or the read strobe is deasserted.
- R5: Each write access gives exactly one single-cycle reg_wr_o pulse after the strobe's trailing edge, with reg_addr_o and reg_wdata_o equal to the address and data held on the bus during the access.
- R6: Each read access gives exactly one single-cycle reg_rd_o pulse, with reg_addr_o set to the access address. reg_rdata_i is sampled in the cycle that follows the pulse and is returned on data_o.
- R7: With mux_en_i = 1, the address used is the value on addr_i at the falling edge of ale_i. Later changes on addr_i have no effect until the next ALE falling edge.
- R8: Addresses RSVD_LO..RSVD_HI (default 0x1C0..0x1FF) are reserved. A write there gives no reg_wr_o. A read there gives no reg_rd_o and returns 0x00 on data_o.
- R9: While rst_ni is low, reg_wr_o, reg_rd_o, data_oe_o, reg_addr_o and reg_wdata_o are all zero.
- R10: Strobes with cs_ni high cause no reg_wr_o, no reg_rd_o and no data_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| style_i | input | 1 | Strobe style: 0 separate read/write, 1 strobe plus direction |
| mux_en_i | input | 1 | Multiplexed-address mode enable |
| ale_i | input | 1 | Address-latch strobe, address taken on its falling edge |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| wr_ni | input | 1 | Write strobe (style 0) or read/write direction (style 1) |
| addr_i | input | 9 | Host address |
| data_i | input | 8 | Host data bus, input side |
| data_o | output | 8 | Host data bus, output side |
| data_oe_o | output | 1 | Data bus output enable for the pad |
| reg_wr_o | output | 1 | Internal write pulse |
| reg_rd_o | output | 1 | Internal read pulse |
| reg_addr_o | output | 9 | Internal access address |
| reg_wdata_o | output | 8 | Internal write data |
| reg_rdata_i | input | 8 | Internal read data, sampled the cycle after reg_rd_o |

## Verification
Writes and reads are driven in both strobe styles with different address and data values.

- Style-0 accesses show that the two strobes are decoded separately.
- Style-1 accesses show that only the direction line chooses read or write.
- Multiplexed accesses change addr_i after the latch strobe falls. This shows whether the latched address or the live pins reach the internal side.
- Accesses into the reserved window check that no pulse is produced and that reads return zero.
- Strobes with chip select high check that nothing is produced.
- Raising the read strobe or chip select during a read checks how quickly the output enable falls.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic {
    BUS_SPLIT = 1'b0,
    BUS_DIR   = 1'b1
  } bus_style_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  bus_style_e style_i,
  input  logic       cs_n_i,
  input  logic       p0_n_i,
  input  logic       p1_i,
  output acc_t       acc_o
);

  always_comb begin
    acc_o = '0;
    if (!cs_n_i) begin
      if (style_i == BUS_SPLIT) begin
        acc_o.rd = !p0_n_i;
        acc_o.wr = !p1_i;
      end else begin
        acc_o.rd = !p0_n_i && p1_i;
        acc_o.wr = !p0_n_i && !p1_i;
      end
    end
  end

endmodule

// File: rtl/hb_addr_sel.sv
module hb_addr_sel #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mux_en_i,
  input  logic          ale_s_i,
  input  logic [AW-1:0] addr_s_i,
  output logic [AW-1:0] addr_now_o,
  output logic [AW-1:0] addr_prev_o
);

  logic [AW-1:0] addr_d_q, lat_q, prev_q;
  logic          ale_q;
  logic          ale_fall;

  assign ale_fall = ale_q && !ale_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_d_q <= '0;
      lat_q    <= '0;
      prev_q   <= '0;
      ale_q    <= 1'b0;
    end else begin
      addr_d_q <= addr_s_i;
      ale_q    <= ale_s_i;
      // address sampled alongside the last high ALE sample
      if (ale_fall) lat_q <= addr_d_q;
      prev_q   <= addr_now_o;
    end
  end

  assign addr_now_o  = mux_en_i ? lat_q : addr_s_i;
  assign addr_prev_o = prev_q;

  p_lat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_fall |=> $stable(lat_q));

endmodule

// File: rtl/hb_host_if.sv
module hb_host_if
  import hb_pkg::*;
#(
  parameter int            AW      = 9,
  parameter int            DW      = 8,
  parameter logic [AW-1:0] RSVD_LO = 9'h1C0,
  parameter logic [AW-1:0] RSVD_HI = 9'h1FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          style_i,
  input  logic          mux_en_i,
  input  logic          ale_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          reg_wr_o,
  output logic          reg_rd_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);

  localparam int BW = AW + DW;

  bus_style_e    style;
  logic [3:0]    ctrl_s;
  logic [BW-1:0] bus_s;
  logic          cs_s, p0_s, p1_s, ale_s;
  logic [AW-1:0] addr_s, addr_now, addr_prev;
  logic [DW-1:0] data_s, data_prev_q;
  acc_t          acc_s, acc_raw;
  logic          rd_act_q, wr_act_q;
  logic          rd_start, wr_end;
  logic          rd_cap_q, rd_rsvd_q, oe_q;
  logic [DW-1:0] rdata_q;

  assign style = bus_style_e'(style_i);

  hb_sync #(.W(4), .RST_VAL(4'b1110)) u_ctrl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, rd_ni, wr_ni, ale_i}),
    .q_o    (ctrl_s)
  );

  hb_sync #(.W(BW), .RST_VAL('0)) u_bus_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({addr_i, data_i}),
    .q_o    (bus_s)
  );

  assign {cs_s, p0_s, p1_s, ale_s} = ctrl_s;
  assign {addr_s, data_s}          = bus_s;

  hb_decode u_dec_s (
    .style_i (style),
    .cs_n_i  (cs_s),
    .p0_n_i  (p0_s),
    .p1_i    (p1_s),
    .acc_o   (acc_s)
  );

  // raw decode gates the output enable so release is not delayed by sync
  hb_decode u_dec_raw (
    .style_i (style),
    .cs_n_i  (cs_ni),
    .p0_n_i  (rd_ni),
    .p1_i    (wr_ni),
    .acc_o   (acc_raw)
  );

  hb_addr_sel #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mux_en_i    (mux_en_i),
    .ale_s_i     (ale_s),
    .addr_s_i    (addr_s),
    .addr_now_o  (addr_now),
    .addr_prev_o (addr_prev)
  );

  function automatic logic is_rsvd(input logic [AW-1:0] a);
    return (a >= RSVD_LO) && (a <= RSVD_HI);
  endfunction

  assign rd_start = acc_s.rd && !rd_act_q;
  assign wr_end   = wr_act_q && !acc_s.wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q    <= 1'b0;
      wr_act_q    <= 1'b0;
      data_prev_q <= '0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      rd_cap_q    <= 1'b0;
      rd_rsvd_q   <= 1'b0;
      rdata_q     <= '0;
      oe_q        <= 1'b0;
    end else begin
      rd_act_q    <= acc_s.rd;
      wr_act_q    <= acc_s.wr;
      data_prev_q <= data_s;
      reg_wr_o    <= wr_end && !is_rsvd(addr_prev);
      reg_rd_o    <= rd_start && !is_rsvd(addr_now);
      rd_cap_q    <= rd_start;
      if (wr_end) begin
        reg_addr_o  <= addr_prev;
        reg_wdata_o <= data_prev_q;
      end else if (rd_start) begin
        reg_addr_o  <= addr_now;
      end
      if (rd_start) rd_rsvd_q <= is_rsvd(addr_now);
      if (rd_cap_q) rdata_q <= rd_rsvd_q ? '0 : reg_rdata_i;
      oe_q        <= acc_s.rd && (oe_q || rd_cap_q);
    end
  end

  assign data_oe_o = oe_q && acc_raw.rd;
  assign data_o    = data_oe_o ? rdata_q : '0;

  p_wr_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  p_rd_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  p_rsvd_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !is_rsvd(reg_addr_o));

  p_oe_no_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !reg_wr_o);

  p_oe_after_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(rd_cap_q));

endmodule

// File: tb/hb_host_if_bench.sv
module hb_host_if_bench;

  localparam time CYC = 4ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       style, mux_en, ale, cs_n, rd_n, wr_n;
  logic [8:0] addr;
  logic [7:0] wdata, dout, reg_wdata, reg_rdata;
  logic       oe, reg_wr, reg_rd;
  logic [8:0] reg_addr;

  int n_run = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  logic [8:0] last_wa, last_ra;
  logic [7:0] last_wd;

  always #(CYC/2) clk = ~clk;

  assign reg_rdata = reg_addr[7:0] ^ 8'hA5;

  hb_host_if u_hb_host_if (
    .clk_i(clk), .rst_ni(rst_n), .style_i(style), .mux_en_i(mux_en),
    .ale_i(ale), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(wdata), .data_o(dout), .data_oe_o(oe),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
    if (reg_rd) begin rd_cnt++; last_ra = reg_addr; end
    if (oe) oe_cnt++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // separate strobes (style 0) or strobe + direction (style 1)
  task automatic do_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (style) wr_n = 1'b0;
    cs_n = 1'b0;
    wait_n(1);
    if (style) rd_n = 1'b0; else wr_n = 1'b0;
    wait_n(4);
    if (style) rd_n = 1'b1; else wr_n = 1'b1;
    wait_n(2);
    cs_n = 1'b1; wr_n = 1'b1;
    wdata = 8'h00;
    wait_n(6);
  endtask

  // starts a read and holds it; caller ends it
  task automatic start_read(input logic [8:0] a);
    @(negedge clk);
    addr = a; wr_n = 1'b1; cs_n = 1'b0;
    wait_n(1);
    rd_n = 1'b0;
    wait_n(8);
  endtask

  task automatic end_read();
    rd_n = 1'b1;
    wait_n(1);
    cs_n = 1'b1;
    wait_n(6);
  endtask

  task automatic t_reset();
    chk(reg_wr == 0 && reg_rd == 0 && oe == 0, "R9 pulses/oe", {reg_wr, reg_rd, oe}, 0);
    chk(reg_addr == 0 && reg_wdata == 0, "R9 addr/wdata", {reg_addr, reg_wdata}, 0);
  endtask

  task automatic t_write(input logic s, input logic [8:0] a, input logic [7:0] d, input string req);
    int c0;
    style = s; c0 = wr_cnt;
    do_write(a, d);
    chk(wr_cnt == c0 + 1, {req, " R5 pulse count"}, wr_cnt - c0, 1);
    chk(last_wa == a, {req, " R5 addr"}, last_wa, a);
    chk(last_wd == d, {req, " R5 data"}, last_wd, d);
  endtask

  task automatic t_read(input logic s, input logic [8:0] a, input string req);
    int c0;
    style = s; c0 = rd_cnt;
    start_read(a);
    chk(rd_cnt == c0 + 1, {req, " R6 pulse count"}, rd_cnt - c0, 1);
    chk(last_ra == a, {req, " R6 addr"}, last_ra, a);
    chk(oe == 1'b1, {req, " R3 oe"}, oe, 1);
    chk(dout == (a[7:0] ^ 8'hA5), {req, " R3 data"}, dout, a[7:0] ^ 8'hA5);
    end_read();
  endtask

  task automatic t_oe_release();
    style = 1'b0;
    start_read(9'h033);
    rd_n = 1'b1;
    #1;
    chk(oe == 1'b0, "R4 rd release", oe, 0);
    end_read();
    style = 1'b1;
    start_read(9'h034);
    wait_n(1);
    cs_n = 1'b1;
    @(posedge clk); #1;
    chk(oe == 1'b0, "R4 cs release", oe, 0);
    rd_n = 1'b1;
    wait_n(6);
  endtask

  task automatic t_mux();
    int c0;
    style = 1'b0; mux_en = 1'b1; c0 = wr_cnt;
    @(negedge clk);
    addr = 9'h0C7; ale = 1'b1;
    wait_n(3);
    ale = 1'b0;
    wait_n(4);
    @(negedge clk);
    wdata = 8'h6E; addr = 9'h011; cs_n = 1'b0;
    wait_n(1); wr_n = 1'b0; wait_n(4); wr_n = 1'b1; wait_n(2); cs_n = 1'b1;
    wait_n(6);
    chk(wr_cnt == c0 + 1, "R7 pulse", wr_cnt - c0, 1);
    chk(last_wa == 9'h0C7, "R7 latched addr", last_wa, 9'h0C7);
    start_read(9'h1F0);
    chk(last_ra == 9'h0C7, "R7 read addr", last_ra, 9'h0C7);
    chk(dout == (8'hC7 ^ 8'hA5), "R7 read data", dout, 8'hC7 ^ 8'hA5);
    end_read();
    mux_en = 1'b0;
  endtask

  task automatic t_rsvd();
    int cw, cr;
    style = 1'b0; cw = wr_cnt; cr = rd_cnt;
    do_write(9'h1C0, 8'h99);
    do_write(9'h1FF, 8'h98);
    chk(wr_cnt == cw, "R8 no write pulse", wr_cnt - cw, 0);
    do_write(9'h1BF, 8'h97);
    chk(wr_cnt == cw + 1 && last_wa == 9'h1BF, "R8 edge below window", last_wa, 9'h1BF);
    start_read(9'h1D5);
    chk(rd_cnt == cr, "R8 no read pulse", rd_cnt - cr, 0);
    chk(oe == 1'b1 && dout == 8'h00, "R8 read zero", dout, 0);
    end_read();
  endtask

  task automatic t_no_cs();
    int cw, cr, co;
    cw = wr_cnt; cr = rd_cnt; co = oe_cnt;
    style = 1'b0;
    @(negedge clk); addr = 9'h044; wdata = 8'h12;
    wr_n = 1'b0; wait_n(5); wr_n = 1'b1; wait_n(2);
    rd_n = 1'b0; wait_n(8); rd_n = 1'b1; wait_n(4);
    style = 1'b1;
    wr_n = 1'b0; rd_n = 1'b0; wait_n(6); rd_n = 1'b1; wr_n = 1'b1; wait_n(6);
    chk(wr_cnt == cw && rd_cnt == cr && oe_cnt == co, "R10 ignored strobes",
        (wr_cnt - cw) + (rd_cnt - cr) + (oe_cnt - co), 0);
  endtask

  initial begin
    rst_n = 1'b0; style = 1'b0; mux_en = 1'b0; ale = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; wdata = '0;
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(3);
    t_write(1'b0, 9'h012, 8'h3C, "R1");
    t_write(1'b0, 9'h155, 8'hF0, "R1");
    t_read(1'b0, 9'h0A9, "R1");
    t_write(1'b1, 9'h0FE, 8'h81, "R2");
    t_read(1'b1, 9'h123, "R2");
    t_read(1'b1, 9'h000, "R2");
    t_oe_release();
    t_mux();
    t_rsvd();
    t_no_cs();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule